// File: doc/BRIEF.md
# Port Inrush Start-Timer Supervisor

This block supervises the turn-on of one powered port. A turn-on command moves it into a ramp phase, where it enables the analog gate driver's controlled ramp and starts a cycle-count start timer. While the ramp runs, a comparator input reports whether the port current is held at the inrush limit. The inrush phase ends once that input has stayed low for a set number of consecutive cycles. If that happens before the timer runs out, the supervisor switches the gate to full enhancement and then raises power-good.

If the timer runs out first, the port is switched off and a start fault is latched. The fault stays set until software clears it, and turn-on commands are refused while it is set. The block also registers the current-threshold code it hands to the analog side. It doubles that code, with saturation, when the coarser sense resistor is selected. Selecting the coarser resistor is the compatible default.

Top module: `pwr_inrush_sup`

## Requirements
- R1: While rst_n is low, gate_en, gate_full, pgood, start_fault and thr_code are all 0.
- R2: cmd_on sampled high in the idle state, with cmd_off low and start_fault clear, enters the ramp state on that edge: gate_en=1 and gate_full=0 from the next cycle.
- R3: at_limit is resynchronised through SYNC_STG flops. Inrush completes on the ramp edge at which the synchronised at_limit has been sampled low on DEB_CYC consecutive ramp edges, and gate_full rises on that edge. A single high sample restarts the count.
- R4: Ramp edges are counted from 1. If the count reaches start_tmo without completion, the supervisor returns to idle on that edge: gate_en drops and start_fault sets together. If completion and expiry fall on the same edge, completion wins.
- R5: pgood rises one clock after gate_full rises and is high only while gate_full is high.
- R6: cmd_off sampled high in any state returns to idle on that edge, so gate_en, gate_full and pgood are 0 the next cycle. cmd_off wins over a simultaneous cmd_on.
- R7: start_fault holds until fault_clr is sampled high, and clears on that edge. If a fault is set on the same edge as a clear, the set wins.
- R8: cmd_on has no effect while start_fault is set: gate_en stays 0.
- R9: thr_code is registered. With sense_half=0 it equals ilim_code. With sense_half=1 it equals min(ilim_code * 2^SCALE_SHIFT, 2^CODE_W-1), with SCALE_SHIFT=1 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Turn-on command |
| cmd_off | input | 1 | Turn-off command |
| fault_clr | input | 1 | Clears the latched start fault |
| start_tmo | input | TMO_W | Start timeout in ramp cycles |
| at_limit | input | 1 | Comparator: port current at inrush limit (asynchronous) |
| sense_half | input | 1 | 1 selects the 0.5 Ω sense scale, 0 the 0.25 Ω scale |
| ilim_code | input | CODE_W | Threshold code for the 0.25 Ω scale |
| gate_en | output | 1 | Gate ramp enable to the analog driver |
| gate_full | output | 1 | Full enhancement permitted |
| pgood | output | 1 | Port power good |
| start_fault | output | 1 | Latched start-timer fault |
| thr_code | output | CODE_W | Scaled threshold code to the analog side |

## Verification
The assertions assume the following input discipline:
- cmd_on and cmd_off are clean synchronous levels.
- fault_clr is a synchronous request.
- start_tmo and ilim_code are held steady across a ramp.

The bench drives every input on the falling edge, changes start_tmo only while the port is idle, and holds at_limit for several cycles before each turn-on, so the synchroniser starts each case from a known value. The sweep covers every timeout from 1 to 16 against every at-limit hold length from 0 to 9. This includes the ties where completion and expiry share an edge.

// File: rtl/inrush_pkg.sv
package inrush_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RAMP = 2'd1,
      ST_FULL = 2'd2
   } sup_state_e;
endpackage

// File: rtl/inrush_sync.sv
module inrush_sync #(
   parameter int STG     = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STG == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= RST_VAL;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STG-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STG{RST_VAL}};
            else        sh_q <= {sh_q[STG-2:0], d};
         end
         assign q = sh_q[STG-1];
      end
   endgenerate
endmodule

// File: rtl/inrush_debounce.sv
module inrush_debounce #(
   parameter int DEB_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic lim,
   output logic done
);
   localparam int RW = (DEB_CYC > 2) ? $clog2(DEB_CYC) : 1;
   localparam logic [RW-1:0] LAST = RW'(DEB_CYC - 1);

   logic [RW-1:0] len_q;

   assign done = run & ~lim & (len_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  len_q <= '0;
      else if (!run || lim || done) len_q <= '0;
      else                          len_q <= len_q + 1'b1;
   end
endmodule

// File: rtl/inrush_timer.sv
module inrush_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] cnt_q;
   logic [TW:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign expired = run & (cnt_inc >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (!cnt_inc[TW])  cnt_q <= cnt_inc[TW-1:0];
   end
endmodule

// File: rtl/inrush_thresh.sv
module inrush_thresh #(
   parameter int CW    = 8,
   parameter int SHIFT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          half,
   input  logic [CW-1:0] code_in,
   output logic [CW-1:0] code_out
);
   localparam int WW = CW + SHIFT;

   logic [WW-1:0] wide;
   logic          ovf;
   logic [CW-1:0] scaled;

   assign wide   = {code_in, {SHIFT{1'b0}}};
   assign ovf    = |wide[WW-1:CW];
   assign scaled = ovf ? {CW{1'b1}} : wide[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_out <= '0;
      else        code_out <= half ? scaled : code_in;
   end
endmodule

// File: rtl/pwr_inrush_sup.sv
module pwr_inrush_sup
   import inrush_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int DEB_CYC     = 4,
   parameter int SYNC_STG    = 2,
   parameter int CODE_W      = 8,
   parameter int SCALE_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_on,
   input  logic              cmd_off,
   input  logic              fault_clr,
   input  logic [TMO_W-1:0]  start_tmo,
   input  logic              at_limit,
   input  logic              sense_half,
   input  logic [CODE_W-1:0] ilim_code,
   output logic              gate_en,
   output logic              gate_full,
   output logic              pgood,
   output logic              start_fault,
   output logic [CODE_W-1:0] thr_code
);
   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
         $error("TMO_W must lie in 2..32");
      end
      if (DEB_CYC < 2 || DEB_CYC > 1024) begin : g_bad_deb
         $error("DEB_CYC must lie in 2..1024");
      end
      if (SYNC_STG < 1 || SYNC_STG > 4) begin : g_bad_sync
         $error("SYNC_STG must lie in 1..4");
      end
      if (CODE_W < 2 || SCALE_SHIFT < 1 || SCALE_SHIFT >= CODE_W) begin : g_bad_code
         $error("CODE_W >= 2 and 1 <= SCALE_SHIFT < CODE_W required");
      end
   endgenerate

   sup_state_e st_q, st_d;
   logic       lim_s;
   logic       ramp_run;
   logic       inrush_done;
   logic       tmo_hit;
   logic       flt_set;
   logic       flt_q;
   logic       full_seen_q;

   assign ramp_run = (st_q == ST_RAMP);

   inrush_sync #(.STG(SYNC_STG), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(at_limit), .q(lim_s)
   );

   inrush_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .run(ramp_run), .lim(lim_s), .done(inrush_done)
   );

   inrush_timer #(.TW(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(ramp_run), .limit(start_tmo), .expired(tmo_hit)
   );

   inrush_thresh #(.CW(CODE_W), .SHIFT(SCALE_SHIFT)) u_thr (
      .clk(clk), .rst_n(rst_n), .half(sense_half), .code_in(ilim_code), .code_out(thr_code)
   );

   always_comb begin
      st_d    = st_q;
      flt_set = 1'b0;
      unique case (st_q)
         ST_IDLE: if (cmd_on && !cmd_off && !flt_q) st_d = ST_RAMP;
         ST_RAMP: begin
            if (cmd_off)          st_d = ST_IDLE;
            else if (inrush_done) st_d = ST_FULL;
            else if (tmo_hit) begin
               st_d    = ST_IDLE;
               flt_set = 1'b1;
            end
         end
         ST_FULL: if (cmd_off) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         flt_q       <= 1'b0;
         full_seen_q <= 1'b0;
      end else begin
         st_q        <= st_d;
         full_seen_q <= (st_q == ST_FULL);
         if (flt_set)        flt_q <= 1'b1;
         else if (fault_clr) flt_q <= 1'b0;
      end
   end

   assign gate_en     = (st_q != ST_IDLE);
   assign gate_full   = (st_q == ST_FULL);
   assign pgood       = (st_q == ST_FULL) & full_seen_q;
   assign start_fault = flt_q;
endmodule

// File: rtl/inrush_sup_chk.sv
module inrush_sup_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_on,
   input logic              cmd_off,
   input logic              fault_clr,
   input logic              sense_half,
   input logic [CODE_W-1:0] ilim_code,
   input logic              gate_en,
   input logic              gate_full,
   input logic              pgood,
   input logic              start_fault,
   input logic [CODE_W-1:0] thr_code
);
   AST_FULL_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      gate_full |-> gate_en); // R3
   AST_PGOOD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> gate_full); // R5
   AST_PGOOD_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> $past(gate_full)); // R5
   AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_fault) |-> (!gate_en && $past(gate_en))); // R4
   AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_off |=> !gate_en); // R6
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_fault && !fault_clr) |=> start_fault); // R7
   AST_FAULT_BLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (start_fault && !gate_en) |=> !gate_en); // R8
   AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && !cmd_on) |=> !gate_en); // R2
   AST_THR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_half && $stable(ilim_code)) |=> (thr_code == $past(ilim_code))); // R9
endmodule

bind pwr_inrush_sup inrush_sup_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
   .fault_clr(fault_clr), .sense_half(sense_half), .ilim_code(ilim_code),
   .gate_en(gate_en), .gate_full(gate_full), .pgood(pgood),
   .start_fault(start_fault), .thr_code(thr_code)
);

// File: tb/sim_pwr_inrush_sup.sv
module sim_pwr_inrush_sup;
   localparam int TW   = 8;
   localparam int DEB  = 3;
   localparam int SYNC = 2;
   localparam int CW   = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_on, cmd_off, fault_clr, at_limit, sense_half;
   logic [TW-1:0] start_tmo;
   logic [CW-1:0] ilim_code;
   logic          gate_en, gate_full, pgood, start_fault;
   logic [CW-1:0] thr_code;

   int  vectors = 0;
   int  fails   = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   pwr_inrush_sup #(.TMO_W(TW), .DEB_CYC(DEB), .SYNC_STG(SYNC),
                    .CODE_W(CW), .SCALE_SHIFT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
      .fault_clr(fault_clr), .start_tmo(start_tmo), .at_limit(at_limit),
      .sense_half(sense_half), .ilim_code(ilim_code), .gate_en(gate_en),
      .gate_full(gate_full), .pgood(pgood), .start_fault(start_fault),
      .thr_code(thr_code)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // status nibble {gate_en, gate_full, pgood, start_fault}
   function automatic logic [31:0] stat();
      return {28'd0, gate_en, gate_full, pgood, start_fault};
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_idle(input logic lim);
      cmd_on = 0; cmd_off = 1; fault_clr = 1; at_limit = lim;
      tick();
      cmd_off = 0; fault_clr = 0;
      repeat (3) tick();
   endtask

   task automatic run_case(input int t, input int h);
      int end_k, fin_k;
      bit ok;
      start_tmo = TW'(t);
      go_idle(h > 0);
      cmd_on = 1;
      tick();
      cmd_on = 0;
      chk("R2 ramp entry", stat(), 32'b1000);
      end_k = (h == 0) ? DEB : h + SYNC + DEB;
      ok    = (end_k <= t);
      fin_k = ok ? end_k : t;
      for (int k = 1; k <= fin_k; k++) begin
         at_limit = (k <= h);
         tick();
         if (k < fin_k)  chk("R3 still ramping", stat(), 32'b1000);
         else if (ok)    chk("R3 inrush done", stat(), 32'b1100);
         else            chk("R4 start timeout", stat(), 32'b0001);
      end
      if (ok) begin
         tick();
         chk("R5 pgood after full", stat(), 32'b1110);
         cmd_off = 1;
         tick();
         cmd_off = 0;
         chk("R6 off from full", stat(), 32'b0000);
      end else begin
         cmd_on = 1;
         tick();
         cmd_on = 0;
         chk("R8 on refused under fault", stat(), 32'b0001);
         fault_clr = 1;
         tick();
         fault_clr = 0;
         chk("R7 fault cleared", stat(), 32'b0000);
      end
   endtask

   initial begin
      rst_n = 0; cmd_on = 0; cmd_off = 0; fault_clr = 0; at_limit = 1;
      sense_half = 1; ilim_code = 8'hff; start_tmo = 8'd10;
      repeat (3) @(negedge clk);
      chk("R1 reset status", stat(), 32'b0000);
      chk("R1 reset code", {24'd0, thr_code}, 32'd0);
      rst_n = 1;
      tick();

      // R3 R4 sweep: every timeout against every hold length
      for (int t = 1; t <= 16; t++)
         for (int h = 0; h <= 9; h++)
            run_case(t, h);

      // R3 restart: raw lows at ramp edges 3,4 and from 6; synced lag 2 -> done at edge 10
      start_tmo = 8'd40;
      go_idle(1'b1);
      cmd_on = 1; tick(); cmd_on = 0;
      for (int k = 1; k <= 10; k++) begin
         at_limit = !(k == 3 || k == 4 || k >= 6);
         tick();
         chk("R3 glitch restart", stat(), (k < 10) ? 32'b1000 : 32'b1100);
      end

      // R6 off during ramp
      go_idle(1'b1);
      cmd_on = 1; tick(); cmd_on = 0;
      tick();
      cmd_off = 1; tick(); cmd_off = 0;
      chk("R6 off mid-ramp", stat(), 32'b0000);
      // R6 off wins over simultaneous on
      cmd_on = 1; cmd_off = 1; tick(); cmd_on = 0; cmd_off = 0;
      chk("R6 off beats on", stat(), 32'b0000);

      // R7 set wins over clear on the same edge (timeout 1)
      start_tmo = 8'd1;
      go_idle(1'b1);
      cmd_on = 1; tick(); cmd_on = 0;
      fault_clr = 1; tick(); fault_clr = 0;
      chk("R7 set beats clear", stat(), 32'b0001);
      tick();
      chk("R7 fault holds", stat(), 32'b0001);

      // R9 threshold code sweep
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 256; c++) begin
            int e;
            sense_half = s[0];
            ilim_code  = CW'(c);
            tick();
            e = (s == 0) ? c : ((2 * c > 255) ? 255 : 2 * c);
            chk("R9 threshold code", {24'd0, thr_code}, e);
         end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule